// File: doc/BRIEF.md
# Pipelined burst SRAM cycle controller

This block is the synchronous control path of a pipelined burst SRAM with a 32-bit word built from four byte lanes and a small internal array. On every rising clock edge it samples the address, three chip selects, two address strobes, a step input and the write controls. From these it classifies the cycle as a deselect, a fresh read, a fresh write, a continued burst step or a held (wait) burst cycle.

Writes reach the array one edge after they are sampled, through per-lane strobes. Reads are captured into an output register, so data for a cycle sampled at edge k is driven after edge k+1. The bus is modelled as a data output plus a drive-enable, gated by an asynchronous active-low output enable. Burst stepping is kept to a plain two-bit wrap of the low address bits, so that the cycle decode can be exercised on its own.

Top module: `sram_burst_ctl`

## Requirements
- R1: When `strobe_cpu_n` is 0, `sel_n` is 0, `exp_en` is 1 and `exp_en_n` is 0, a new address is taken and the cycle is a read, even if the write controls request a write.
- R2: `strobe_cpu_n` is ignored while `sel_n` is 1. With `sel_n` at 1 and `strobe_ctl_n` at 0 the cycle is a deselect. With `sel_n` at 1 and `strobe_ctl_n` at 1, an active burst continues.
- R3: A deselect occurs when an honoured strobe is low and `exp_en` is 0 or `exp_en_n` is 1. It ends the burst, and the output slot that follows carries no driven data.
- R4: `strobe_ctl_n` at 0 with all selects active takes a new address. The cycle is a write when the effective write is active and a read otherwise.
- R5: With both strobes high and a burst active, `step_n` at 0 moves to the next address, with the low two address bits incremented modulo 4 and the upper bits kept. `step_n` at 1 repeats the current address. Each such cycle reads or writes according to the effective write.
- R6: The effective write is active when `wr_all_n` is 0, or when `wr_gate_n` is 0 and at least one bit of `lane_n` is 0. Lane bits with `wr_gate_n` at 1 write nothing.
- R7: `wr_all_n` at 0 writes all four lanes. Otherwise `lane_n[i]` at 0 writes bits 8i+7:8i (bit 0 for bits 7:0, up to bit 3 for bits 31:24).
- R8: A write can follow a strobe_cpu read at the same address by asserting the write controls in the next cycle with both strobes high and `step_n` at 1.
- R9: `rdata_drive` follows `out_en_n` without waiting for a clock. It stays 0 while the most recently sampled cycle is a write, whatever `out_en_n` is.
- R10: While `rst_n` is 0, and after reset until a read's data arrives, `rdata_drive` is 0.
- R11: Read data for a cycle sampled at edge k appears on `rdata` with `rdata_drive` at 1 after edge k+1, and it reflects every write sampled before edge k.
- R12: With both strobes high and no active burst (after reset or after a deselect), the cycle does nothing: no write and no driven data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| sel_n | input | 1 | Primary chip select, active low, gates strobe_cpu_n |
| exp_en | input | 1 | Depth-expansion select, active high |
| exp_en_n | input | 1 | Depth-expansion select, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, always starts a read |
| strobe_ctl_n | input | 1 | Controller-side address strobe, starts read or write |
| step_n | input | 1 | Burst step when 0, wait cycle when 1 |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_gate_n | input | 1 | Gate for the per-lane write bits, active low |
| lane_n | input | 4 | Per-lane write bits, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 32 | Write data, sampled with the write cycle |
| rdata | output | 32 | Registered read data |
| rdata_drive | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The hardest situation to reach from the ports is a pipelined read slot that overlaps a write. This occurs in a write that follows a strobe_cpu read through a wait cycle, where the read data is ready but the bus must stay quiet and the write must land at the read's address. Directed sequences build that pair on purpose, and also the burst wrap from address 3 to 0 of a group. The random phase mixes strobes, selects and write controls so that bursts are often continued or suspended with lanes partly set. A bench model of the array applies the lane masks, and each read is compared against it.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  localparam int unsigned LANE_CNT = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned WORD_W   = LANE_CNT * LANE_W;

  // Kind of access a sampled cycle performs on the array.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // What the burst pointer does at the edge.
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_STEP = 2'd2,
    PTR_DROP = 2'd3
  } ptr_e;

  // Active-low effective write from the whole-word and per-lane controls.
  function automatic logic eff_write_n(input logic all_n,
                                       input logic gate_n,
                                       input logic [LANE_CNT-1:0] lane_n);
    return (gate_n | (&lane_n)) & all_n;
  endfunction

  // Lanes written by a write cycle.
  function automatic logic [LANE_CNT-1:0] lane_mask(input logic all_n,
                                                    input logic gate_n,
                                                    input logic [LANE_CNT-1:0] lane_n);
    if (!all_n)  return '1;
    if (!gate_n) return ~lane_n;
    return '0;
  endfunction

  // Two-bit wrap of the low address bits inside a four-word group.
  function automatic logic [1:0] wrap_step(input logic [1:0] lo);
    return lo + 2'd1;
  endfunction

endpackage

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
  import sram_burst_pkg::*;
(
  input  logic                burst_act,
  input  logic                sel_n,
  input  logic                exp_en,
  input  logic                exp_en_n,
  input  logic                strobe_cpu_n,
  input  logic                strobe_ctl_n,
  input  logic                step_n,
  input  logic                wr_all_n,
  input  logic                wr_gate_n,
  input  logic [LANE_CNT-1:0] lane_n,
  output op_e                 cyc_op,
  output ptr_e                ptr_op,
  output logic [LANE_CNT-1:0] cyc_lanes
);

  logic wr_n;
  logic selected;
  logic cpu_take;

  assign wr_n     = eff_write_n(wr_all_n, wr_gate_n, lane_n);
  assign selected = ~sel_n & exp_en & ~exp_en_n;
  assign cpu_take = ~strobe_cpu_n & ~sel_n;

  always_comb begin
    cyc_op = OP_NONE;
    ptr_op = PTR_HOLD;
    if (cpu_take) begin
      if (selected) begin
        cyc_op = OP_READ;
        ptr_op = PTR_LOAD;
      end else begin
        ptr_op = PTR_DROP;
      end
    end else if (!strobe_ctl_n) begin
      if (selected) begin
        cyc_op = wr_n ? OP_READ : OP_WRITE;
        ptr_op = PTR_LOAD;
      end else begin
        ptr_op = PTR_DROP;
      end
    end else if (burst_act) begin
      cyc_op = wr_n ? OP_READ : OP_WRITE;
      ptr_op = step_n ? PTR_HOLD : PTR_STEP;
    end
  end

  assign cyc_lanes = (cyc_op == OP_WRITE) ? lane_mask(wr_all_n, wr_gate_n, lane_n) : '0;

endmodule

// File: rtl/sram_burst_ptr.sv
module sram_burst_ptr
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptr_e              ptr_op,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_act
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      burst_act <= 1'b0;
    end else begin
      case (ptr_op)
        PTR_LOAD: begin
          cur_addr  <= ext_addr;
          burst_act <= 1'b1;
        end
        PTR_STEP: cur_addr <= {cur_addr[ADDR_W-1:2], wrap_step(cur_addr[1:0])};
        PTR_DROP: burst_act <= 1'b0;
        default:  ;
      endcase
    end
  end

  // R5: a wait cycle repeats the address
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_op == PTR_HOLD) |=> $stable(cur_addr));

  // R5: a step keeps the upper bits of the group
  a_r5_step_group: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_op == PTR_STEP) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R4: a load takes the external address and opens a burst
  a_r4_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_op == PTR_LOAD) |=> (cur_addr == $past(ext_addr)) && burst_act);

  // R3: a deselect closes the burst
  a_r3_drop_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_op == PTR_DROP) |=> !burst_act);

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LANE_CNT-1:0] lane_we,
  input  logic [WORD_W-1:0]   wr_word,
  output logic [WORD_W-1:0]   rd_word
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[addr];
  end

endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                sel_n,
  input  logic                exp_en,
  input  logic                exp_en_n,
  input  logic                strobe_cpu_n,
  input  logic                strobe_ctl_n,
  input  logic                step_n,
  input  logic                wr_all_n,
  input  logic                wr_gate_n,
  input  logic [LANE_CNT-1:0] lane_n,
  input  logic                out_en_n,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                rdata_drive
);

  op_e                 cyc_op;
  ptr_e                ptr_op;
  logic [LANE_CNT-1:0] cyc_lanes;
  logic [ADDR_W-1:0]   cur_addr;
  logic                burst_act;
  logic [WORD_W-1:0]   arr_rd;

  // Stage 1: the sampled cycle, executed on the array at the next edge.
  op_e                 s1_op;
  logic [LANE_CNT-1:0] s1_lanes;
  logic [WORD_W-1:0]   s1_data;

  // Output register stage.
  logic                out_vld;
  logic [WORD_W-1:0]   out_q;

  sram_cyc_decode u_decode (
    .burst_act    (burst_act),
    .sel_n        (sel_n),
    .exp_en       (exp_en),
    .exp_en_n     (exp_en_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .step_n       (step_n),
    .wr_all_n     (wr_all_n),
    .wr_gate_n    (wr_gate_n),
    .lane_n       (lane_n),
    .cyc_op       (cyc_op),
    .ptr_op       (ptr_op),
    .cyc_lanes    (cyc_lanes)
  );

  sram_burst_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_op    (ptr_op),
    .ext_addr  (addr),
    .cur_addr  (cur_addr),
    .burst_act (burst_act)
  );

  sram_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .addr    (cur_addr),
    .lane_we (s1_lanes),
    .wr_word (s1_data),
    .rd_word (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_NONE;
      s1_lanes <= '0;
      s1_data  <= '0;
      out_vld  <= 1'b0;
      out_q    <= '0;
    end else begin
      s1_op    <= cyc_op;
      s1_lanes <= cyc_lanes;
      s1_data  <= wdata;
      out_vld  <= (s1_op == OP_READ);
      if (s1_op == OP_READ) out_q <= arr_rd;
    end
  end

  assign rdata       = out_q;
  assign rdata_drive = out_vld & ~out_en_n & (s1_op != OP_WRITE);

  // R10: quiet bus while in reset
  always_comb begin
    if (!rst_n) a_r10_quiet_reset: assert (!rdata_drive);
  end

  // R9: a sampled write keeps the bus quiet
  a_r9_write_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_WRITE) |-> !rdata_drive);

  // R1: strobe_cpu with full select always yields a read
  a_r1_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && !sel_n && exp_en && !exp_en_n) |=> (s1_op == OP_READ));

  // R3: a deselect leaves the following output slot empty
  a_r3_desel_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ((!exp_en || exp_en_n) && ((!strobe_cpu_n && !sel_n) || !strobe_ctl_n))
      |=> ##1 !out_vld);

  // R11: a read fills the output register at the following edge
  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_READ) |=> out_vld);

  // R7: lane strobes only fire for a write
  a_r7_lanes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|s1_lanes) |-> (s1_op == OP_WRITE));

endmodule

// File: tb/sram_burst_ctl_tb.sv
module sram_burst_ctl_tb;

  localparam int unsigned AW    = 6;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_n, exp_en, exp_en_n;
  logic          strobe_cpu_n, strobe_ctl_n, step_n;
  logic          wr_all_n, wr_gate_n;
  logic [3:0]    lane_n;
  logic          out_en_n;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          rdata_drive;

  always #2.5 clk = ~clk;

  sram_burst_ctl #(.ADDR_W(AW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .sel_n        (sel_n),
    .exp_en       (exp_en),
    .exp_en_n     (exp_en_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .step_n       (step_n),
    .wr_all_n     (wr_all_n),
    .wr_gate_n    (wr_gate_n),
    .lane_n       (lane_n),
    .out_en_n     (out_en_n),
    .wdata        (wdata),
    .rdata        (rdata),
    .rdata_drive  (rdata_drive)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0]   mem_ref [DEPTH];
  logic          m_act = 1'b0;
  logic [AW-1:0] m_addr = '0;
  int            p_op = 0;       // 0 none, 1 read, 2 write
  logic [AW-1:0] p_addr = '0;
  logic [3:0]    p_lanes = '0;
  logic [31:0]   p_data = '0;
  logic          e_vld = 1'b0;
  logic [31:0]   e_q = '0;
  int            cur_op = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic bench_write(input logic all_n, input logic gate_n, input logic [3:0] ln);
    if (!all_n) return 1'b1;
    return !gate_n && (ln != 4'hF);
  endfunction

  task automatic idle_pins();
    sel_n = 0; exp_en = 1; exp_en_n = 0;
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_gate_n = 1; lane_n = 4'hF;
    out_en_n = 0;
  endtask

  task automatic check_bus(input string tag);
    logic exp_drv;
    exp_drv = e_vld && !out_en_n && (cur_op != 2);
    chk(tag, {31'd0, rdata_drive}, {31'd0, exp_drv});
    if (exp_drv) chk(tag, rdata, e_q);
  endtask

  task automatic tick(input string tag);
    logic sel;
    logic wr;
    int   op;
    @(posedge clk); #1;
    if (p_op == 2)
      for (int i = 0; i < 4; i++)
        if (p_lanes[i]) mem_ref[p_addr][8*i +: 8] = p_data[8*i +: 8];
    e_vld = (p_op == 1);
    if (e_vld) e_q = mem_ref[p_addr];
    wr  = bench_write(wr_all_n, wr_gate_n, lane_n);
    sel = !sel_n && exp_en && !exp_en_n;
    op  = 0;
    if (!strobe_cpu_n && !sel_n) begin
      if (sel) begin m_addr = addr; m_act = 1; op = 1; end
      else m_act = 0;
    end else if (!strobe_ctl_n) begin
      if (sel) begin m_addr = addr; m_act = 1; op = wr ? 2 : 1; end
      else m_act = 0;
    end else if (m_act) begin
      if (!step_n) m_addr[1:0] = m_addr[1:0] + 2'd1;
      op = wr ? 2 : 1;
    end
    p_op    = op;
    p_addr  = m_addr;
    p_lanes = (op != 2) ? 4'h0 : (!wr_all_n ? 4'hF : ~lane_n);
    p_data  = wdata;
    cur_op  = op;
    check_bus(tag);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; addr = '0; wdata = '0;
    idle_pins();
    repeat (3) @(negedge clk);
    chk("R10 in reset", {31'd0, rdata_drive}, 32'd0);
    rst_n = 1;
    tick("R10");
    tick("R12 idle after reset");

    // Fill the array with whole-word writes (R4, R7 all lanes)
    for (int i = 0; i < DEPTH; i++) begin
      idle_pins(); strobe_ctl_n = 0; addr = AW'(i); wr_all_n = 0;
      wdata = 32'hA5000000 ^ (i * 32'h01030507);
      tick("R4 fill");
    end
    idle_pins(); exp_en = 0; strobe_ctl_n = 0; tick("R3 deselect");
    idle_pins(); tick("R3 slot quiet");

    // R1: strobe_cpu read ignores the write controls
    idle_pins(); strobe_cpu_n = 0; addr = 6'd5; wr_all_n = 0; wdata = 32'hDEADBEEF;
    tick("R1");
    idle_pins(); exp_en = 0; strobe_ctl_n = 0; tick("R1 data");
    idle_pins(); tick("R3 quiet");

    // R5: burst with wrap, then wait cycle
    idle_pins(); strobe_ctl_n = 0; addr = 6'd6; tick("R5 start");
    idle_pins(); step_n = 0; tick("R5 step");
    tick("R5 step wrap");
    tick("R5 step");
    idle_pins(); step_n = 1; tick("R5 wait");
    tick("R5 wait");

    // R7: single-lane write, read back
    idle_pins(); strobe_ctl_n = 0; addr = 6'd10; wr_gate_n = 0; lane_n = 4'b1101;
    wdata = 32'h11223344; tick("R7 lane1 write");
    idle_pins(); strobe_ctl_n = 0; addr = 6'd10; tick("R7 read");
    tick("R7 data");

    // R6: lane bits without the gate are not a write
    idle_pins(); strobe_ctl_n = 0; addr = 6'd11; wr_gate_n = 1; lane_n = 4'h0;
    wdata = 32'h0BADF00D; tick("R6 not write");
    idle_pins(); strobe_ctl_n = 0; addr = 6'd11; tick("R6 read");
    tick("R6 data");

    // R8: write after strobe_cpu read through a wait cycle
    idle_pins(); strobe_cpu_n = 0; addr = 6'd20; tick("R8 read");
    idle_pins(); wr_all_n = 0; wdata = 32'hCAFE0020; tick("R8 wait write");
    idle_pins(); strobe_ctl_n = 0; addr = 6'd20; tick("R8 readback");
    tick("R8 data");

    // R9: output enable gating, asynchronous
    idle_pins(); strobe_ctl_n = 0; addr = 6'd21; tick("R9 read");
    idle_pins(); exp_en = 0; strobe_ctl_n = 0; out_en_n = 1; tick("R9 oe off");
    out_en_n = 0; #1;
    chk("R9 async on", {31'd0, rdata_drive}, {31'd0, e_vld && (cur_op != 2)});
    if (e_vld) chk("R9 async data", rdata, e_q);
    @(negedge clk);

    // R2: sel_n high ignores strobe_cpu; strobe_ctl then deselects
    idle_pins(); strobe_ctl_n = 0; addr = 6'd30; tick("R2 start");
    idle_pins(); sel_n = 1; strobe_cpu_n = 0; step_n = 0; tick("R2 burst continues");
    tick("R2 data");
    idle_pins(); sel_n = 1; strobe_ctl_n = 0; tick("R2 deselect");
    idle_pins(); tick("R2 quiet");

    // R12: no burst open, write controls have no effect
    idle_pins(); wr_all_n = 0; addr = 6'd40; wdata = 32'hFFFFFFFF; tick("R12 no op");
    idle_pins(); tick("R12 quiet");
    idle_pins(); strobe_ctl_n = 0; addr = 6'd40; tick("R12 read");
    tick("R12 data");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      addr         = AW'($urandom);
      sel_n        = ($urandom % 10) == 0;
      exp_en       = ($urandom % 10) != 0;
      exp_en_n     = ($urandom % 10) == 0;
      strobe_cpu_n = ($urandom % 5) != 0;
      strobe_ctl_n = ($urandom % 4) != 0;
      step_n       = $urandom % 2;
      wr_all_n     = ($urandom % 5) != 0;
      wr_gate_n    = ($urandom % 5) >= 2;
      lane_n       = 4'($urandom);
      out_en_n     = ($urandom % 7) == 0;
      wdata        = $urandom;
      tick("R11 random");
    end

    summary();
  end

endmodule